// File: doc/BRIEF.md
# Autonegotiation Advertisement and Restart Sequencer

This block sets up a copper PHY for autonegotiation. It uses a generic register-access port that the surrounding logic connects to an MDIO master or to a simple request/acknowledge bus. A one-cycle `start` pulse latches a requested-capability mask, a capability-support mask, a flow-control mode and a wait option. The sequencer then reads the advertisement registers, removes the old speed bits and merges in the requested speeds and pause bits. It writes the registers back and restarts negotiation with a read-modify-write of the PHY control register.

When waiting is enabled, the block polls the PHY status register until negotiation completes or the attempt limit is reached. Each attempt reads the status register twice, because some of its bits are latched. A programmable number of cycles separates two attempts. At the end of every run, `done` pulses for one cycle. A run that ends without error also pulses `recheck`, which tells the link logic to sample the link state again. A configuration error and a bus error are reported on separate flags, which stay set until the next start.

Capability bit encoding, used by `cap_req` and `cap_support`:
- bit 0: 10 Mb/s half duplex
- bit 1: 10 Mb/s full duplex
- bit 2: 100 Mb/s half duplex
- bit 3: 100 Mb/s full duplex
- bit 4: 1000 Mb/s half duplex
- bit 5: 1000 Mb/s full duplex
- bit 6: 2500 Mb/s half duplex
- bit 7: 2500 Mb/s full duplex

Flow-control mode encoding, used by `fc_mode`:
- 0: none
- 1: receive-only
- 2: transmit-only
- 3: both directions

Top module: `an_adv_seq`

## Requirements
- R1: The speeds advertised are `cap_req & cap_support`, latched at start. When that product is zero, `cap_support` is advertised in full.
- R2: The sequence reads register 4 first. It then reads register 9, but only when `cap_support` bit 5 is set. It then reads the multi-gigabit register, at address (7<<16)|0x20, but only when `cap_support` bit 7 is set. Each register is later written only if it was read.
- R3: In register 4 the speed bits are 10H at bit 5, 10F at bit 6, 100H at bit 7 and 100F at bit 8. All four are cleared, then set from the advertised mask. Register 9 bit 9 is set from mask bit 5, and register 0x20 bit 7 is set from mask bit 7. All other bits are written back as they were read.
- R4: Register 9 bit 8 (gigabit half duplex) is always written as 0. Mask bits 4 and 6 (1000 and 2500 half duplex) have no effect on any register.
- R5: Pause bits in register 4 are bit 10 (pause) and bit 11 (asymmetric direction). Mode 0 clears both, modes 1 and 3 set both, and mode 2 sets bit 11 and clears bit 10.
- R6: A mode value of 4 to 7 ends the run after the reads. It sets `err_cfg` and performs no register write.
- R7: Negotiation restarts through a read of register 0, followed by a write of the value read with bit 12 (autoneg enable) and bit 9 (restart) set.
- R8: With `wait_done_en` set, each attempt reads register 1 twice. The run stops when the second read has bit 5 set, which also sets `an_complete`. After `POLL_LIMIT` attempts the run stops without an error.
- R9: At least `DELAY_CYC` cycles separate the end of one poll attempt from the first read of the next.
- R10: An error response on any access ends the run immediately. It sets `err_bus`, and no further access is made.
- R11: `done` pulses for one cycle at the end of every run. `recheck` pulses together with it only when neither error flag is set.
- R12: `phy_req` stays high, with address, write flag and write data stable, until `phy_ack` is seen. It then drops for at least one cycle.
- R13: After reset the block is idle: `busy`, `phy_req`, the error flags and `an_complete` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| cap_req | input | 8 | Requested capability mask |
| cap_support | input | 8 | Capability-support mask |
| fc_mode | input | 3 | Requested flow-control mode |
| wait_done_en | input | 1 | Poll for negotiation completion |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| recheck | output | 1 | One-cycle pulse on a clean end of run |
| an_complete | output | 1 | Negotiation seen complete during polling |
| err_cfg | output | 1 | Invalid flow-control mode |
| err_bus | output | 1 | Access returned an error |
| phy_req | output | 1 | Register access request |
| phy_we | output | 1 | Access is a write |
| phy_addr | output | ADDR_W | Register address (MMD device in bits above 16) |
| phy_wdata | output | DATA_W | Write data |
| phy_ack | input | 1 | Access accepted and finished |
| phy_rdata | input | DATA_W | Read data, valid with `phy_ack` |
| phy_err | input | 1 | Error response, valid with `phy_ack` |

## Verification
The assertions check the following on every cycle:
- the request handshake stays stable until it is acknowledged;
- no write of register 9 ever carries the half-duplex gigabit bit;
- every write of register 4 carries the pause pattern of the latched mode;
- every control write carries both restart bits;
- no access follows a configuration error;
- `done` never lasts more than one cycle;
- the attempt counter stays within its limit.

Some behaviour only the bench scenarios can show:
- the merged register values seen by a PHY model for each mask and mode;
- the skipping of registers the support mask excludes;
- the exact number of status reads for early completion and for exhaustion;
- the spacing between attempts;
- the fact that a bus error leaves the PHY registers untouched.

// File: rtl/an_seq_pkg.sv
package an_seq_pkg;

   localparam int CAP_W = 8;

   // capability mask positions
   localparam int CAP_10H   = 0;
   localparam int CAP_1000H = 4;
   localparam int CAP_1000F = 5;
   localparam int CAP_2500H = 6;
   localparam int CAP_2500F = 7;

   // PHY register addresses
   localparam int REG_CTL  = 0;
   localparam int REG_STAT = 1;
   localparam int REG_ADV  = 4;
   localparam int REG_GIG  = 9;
   localparam int MMD_DEV  = 7;
   localparam int MMD_SHIFT = 16;
   localparam int MG_REG   = 32;

   // bit positions inside PHY registers
   localparam int ADV_SPD_LO  = 5;
   localparam int ADV_PAUSE   = 10;
   localparam int ADV_ASM     = 11;
   localparam int GIG_HD      = 8;
   localparam int GIG_FD      = 9;
   localparam int MG_FD       = 7;
   localparam int CTL_AN_EN   = 12;
   localparam int CTL_RESTART = 9;
   localparam int STAT_AN_OK  = 5;

   localparam logic [2:0] FC_NONE = 3'd0;
   localparam logic [2:0] FC_RX   = 3'd1;
   localparam logic [2:0] FC_TX   = 3'd2;
   localparam logic [2:0] FC_FULL = 3'd3;

   typedef enum logic [3:0] {
      S_IDLE, S_RD_ADV, S_RD_GIG, S_RD_MG, S_CHK,
      S_WR_ADV, S_WR_GIG, S_WR_MG, S_RD_CTL, S_WR_CTL,
      S_POLL_A, S_POLL_B, S_DELAY, S_FINISH
   } seq_state_t;

endpackage

// File: rtl/an_reg_port.sv
module an_reg_port #(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              go_we,
   input  logic [ADDR_W-1:0] go_addr,
   input  logic [DATA_W-1:0] go_wdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_err,
   output logic              fin,
   output logic              fin_err,
   output logic [DATA_W-1:0] fin_rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_req   <= 1'b0;
         bus_we    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         fin       <= 1'b0;
         fin_err   <= 1'b0;
         fin_rdata <= '0;
      end else begin
         fin     <= bus_req & bus_ack;
         fin_err <= bus_req & bus_ack & bus_err;
         if (bus_req && bus_ack) begin
            bus_req   <= 1'b0;
            fin_rdata <= bus_rdata;
         end else if (go) begin
            bus_req   <= 1'b1;
            bus_we    <= go_we;
            bus_addr  <= go_addr;
            bus_wdata <= go_wdata;
         end
      end
   end

   // R12: request and its payload hold until acknowledged
   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                              && $stable(bus_wdata));
   // R12: a new access is never launched over a pending one
   p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !bus_req);
   // R12: request drops after acknowledge
   p_req_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack |=> !bus_req);

endmodule

// File: rtl/an_adv_calc.sv
module an_adv_calc
   import an_seq_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int HAS_MGIG = 1
) (
   input  logic [DATA_W-1:0] adv_in,
   input  logic [DATA_W-1:0] gig_in,
   input  logic [DATA_W-1:0] mg_in,
   input  logic [CAP_W-1:0]  spd_mask,
   input  logic [2:0]        fc_mode,
   output logic [DATA_W-1:0] adv_out,
   output logic [DATA_W-1:0] gig_out,
   output logic [DATA_W-1:0] mg_out,
   output logic              mode_bad
);

   localparam int N_LOW_SPD = 4;

   always_comb begin
      adv_out  = adv_in;
      mode_bad = 1'b0;
      for (int i = 0; i < N_LOW_SPD; i++) begin
         adv_out[ADV_SPD_LO + i] = spd_mask[CAP_10H + i];
      end
      case (fc_mode)
         FC_NONE: begin
            adv_out[ADV_PAUSE] = 1'b0;
            adv_out[ADV_ASM]   = 1'b0;
         end
         FC_RX, FC_FULL: begin
            adv_out[ADV_PAUSE] = 1'b1;
            adv_out[ADV_ASM]   = 1'b1;
         end
         FC_TX: begin
            adv_out[ADV_PAUSE] = 1'b0;
            adv_out[ADV_ASM]   = 1'b1;
         end
         default: mode_bad = 1'b1;
      endcase
   end

   // half-duplex gigabit requests are refused; only full duplex is carried
   always_comb begin
      gig_out         = gig_in;
      gig_out[GIG_HD] = 1'b0;
      gig_out[GIG_FD] = spd_mask[CAP_1000F];
   end

   generate
      if (HAS_MGIG != 0) begin : g_mgig
         always_comb begin
            mg_out        = mg_in;
            mg_out[MG_FD] = spd_mask[CAP_2500F];
         end
      end else begin : g_no_mgig
         assign mg_out = mg_in;
      end
   endgenerate

endmodule

// File: rtl/an_poll_timer.sv
module an_poll_timer #(
   parameter int POLL_LIMIT = 45,
   parameter int DELAY_CYC  = 20_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic attempt_inc,
   input  logic delay_run,
   output logic last_attempt,
   output logic delay_done
);

   localparam int ATT_W = $clog2(POLL_LIMIT + 1);
   localparam int DLY_W = $clog2(DELAY_CYC + 1);

   logic [ATT_W-1:0] att_cnt;
   logic [DLY_W-1:0] dly_cnt;

   assign last_attempt = (att_cnt == ATT_W'(POLL_LIMIT - 1));
   assign delay_done   = delay_run && (dly_cnt == DLY_W'(DELAY_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         att_cnt <= '0;
      end else if (attempt_inc && att_cnt != ATT_W'(POLL_LIMIT)) begin
         att_cnt <= att_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !delay_run || delay_done) begin
         dly_cnt <= '0;
      end else begin
         dly_cnt <= dly_cnt + 1'b1;
      end
   end

   // R8: attempts never exceed the limit
   p_attempt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      att_cnt <= ATT_W'(POLL_LIMIT));
   // R9: delay counter stays within its window while running
   p_delay_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      delay_run |-> dly_cnt < DLY_W'(DELAY_CYC));

endmodule

// File: rtl/an_adv_seq.sv
module an_adv_seq
   import an_seq_pkg::*;
#(
   parameter int ADDR_W     = 21,
   parameter int DATA_W     = 16,
   parameter int POLL_LIMIT = 45,
   parameter int DELAY_CYC  = 20_000_000,
   parameter int HAS_MGIG   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        cap_req,
   input  logic [7:0]        cap_support,
   input  logic [2:0]        fc_mode,
   input  logic              wait_done_en,
   output logic              busy,
   output logic              done,
   output logic              recheck,
   output logic              an_complete,
   output logic              err_cfg,
   output logic              err_bus,
   output logic              phy_req,
   output logic              phy_we,
   output logic [ADDR_W-1:0] phy_addr,
   output logic [DATA_W-1:0] phy_wdata,
   input  logic              phy_ack,
   input  logic [DATA_W-1:0] phy_rdata,
   input  logic              phy_err
);

   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(REG_CTL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
   localparam logic [ADDR_W-1:0] A_ADV  = ADDR_W'(REG_ADV);
   localparam logic [ADDR_W-1:0] A_GIG  = ADDR_W'(REG_GIG);
   localparam logic [ADDR_W-1:0] A_MG   = ADDR_W'((MMD_DEV << MMD_SHIFT) | MG_REG);
   localparam logic [DATA_W-1:0] CTL_SET =
      (DATA_W'(1) << CTL_AN_EN) | (DATA_W'(1) << CTL_RESTART);

   generate
      if (ADDR_W < MMD_SHIFT + 3) begin : g_bad_addr
         $error("ADDR_W too small to carry the MMD device field");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("DATA_W must hold a 16-bit PHY register");
      end
      if (POLL_LIMIT < 1) begin : g_bad_poll
         $error("POLL_LIMIT must be at least 1");
      end
      if (DELAY_CYC < 1) begin : g_bad_dly
         $error("DELAY_CYC must be at least 1");
      end
   endgenerate

   seq_state_t state;
   logic              issued;
   logic [CAP_W-1:0]  mask_q, sup_q;
   logic [2:0]        mode_q;
   logic              wait_q;
   logic [DATA_W-1:0] adv_q, gig_q, mg_q, ctl_q;

   logic              op_act, op_we, go;
   logic [ADDR_W-1:0] op_addr;
   logic [DATA_W-1:0] op_wd;
   logic              fin, fin_err;
   logic [DATA_W-1:0] fin_rdata;
   logic [DATA_W-1:0] adv_new, gig_new, mg_new;
   logic              mode_bad;
   logic              last_att, dly_done, att_inc;
   logic              sup_gig, sup_mg;
   logic [CAP_W-1:0]  eff_mask;

   assign sup_gig  = sup_q[CAP_1000F];
   assign sup_mg   = (HAS_MGIG != 0) && sup_q[CAP_2500F];
   assign eff_mask = cap_req & cap_support;

   // access decode per state
   always_comb begin
      op_act  = 1'b1;
      op_we   = 1'b0;
      op_addr = '0;
      op_wd   = '0;
      case (state)
         S_RD_ADV: op_addr = A_ADV;
         S_RD_GIG: op_addr = A_GIG;
         S_RD_MG:  op_addr = A_MG;
         S_WR_ADV: begin op_we = 1'b1; op_addr = A_ADV; op_wd = adv_q; end
         S_WR_GIG: begin op_we = 1'b1; op_addr = A_GIG; op_wd = gig_q; end
         S_WR_MG:  begin op_we = 1'b1; op_addr = A_MG;  op_wd = mg_q;  end
         S_RD_CTL: op_addr = A_CTL;
         S_WR_CTL: begin op_we = 1'b1; op_addr = A_CTL; op_wd = ctl_q | CTL_SET; end
         S_POLL_A, S_POLL_B: op_addr = A_STAT;
         default: op_act = 1'b0;
      endcase
   end

   assign go      = op_act && !issued;
   assign att_inc = (state == S_POLL_B) && fin && !fin_err;

   an_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_port (
      .clk(clk), .rst_n(rst_n),
      .go(go), .go_we(op_we), .go_addr(op_addr), .go_wdata(op_wd),
      .bus_req(phy_req), .bus_we(phy_we), .bus_addr(phy_addr), .bus_wdata(phy_wdata),
      .bus_ack(phy_ack), .bus_rdata(phy_rdata), .bus_err(phy_err),
      .fin(fin), .fin_err(fin_err), .fin_rdata(fin_rdata)
   );

   an_adv_calc #(.DATA_W(DATA_W), .HAS_MGIG(HAS_MGIG)) i_calc (
      .adv_in(adv_q), .gig_in(gig_q), .mg_in(mg_q),
      .spd_mask(mask_q), .fc_mode(mode_q),
      .adv_out(adv_new), .gig_out(gig_new), .mg_out(mg_new),
      .mode_bad(mode_bad)
   );

   an_poll_timer #(.POLL_LIMIT(POLL_LIMIT), .DELAY_CYC(DELAY_CYC)) i_timer (
      .clk(clk), .rst_n(rst_n),
      .clear(state == S_IDLE),
      .attempt_inc(att_inc),
      .delay_run(state == S_DELAY),
      .last_attempt(last_att),
      .delay_done(dly_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         issued      <= 1'b0;
         mask_q      <= '0;
         sup_q       <= '0;
         mode_q      <= '0;
         wait_q      <= 1'b0;
         adv_q       <= '0;
         gig_q       <= '0;
         mg_q        <= '0;
         ctl_q       <= '0;
         an_complete <= 1'b0;
         err_cfg     <= 1'b0;
         err_bus     <= 1'b0;
      end else begin
         if (go) issued <= 1'b1;
         if (fin) issued <= 1'b0;

         if (fin && fin_err) begin
            err_bus <= 1'b1;
            state   <= S_FINISH;
         end else begin
            case (state)
               S_IDLE: if (start) begin
                  mask_q      <= (eff_mask == '0) ? cap_support : eff_mask;
                  sup_q       <= cap_support;
                  mode_q      <= fc_mode;
                  wait_q      <= wait_done_en;
                  gig_q       <= '0;
                  mg_q        <= '0;
                  an_complete <= 1'b0;
                  err_cfg     <= 1'b0;
                  err_bus     <= 1'b0;
                  state       <= S_RD_ADV;
               end
               S_RD_ADV: if (fin) begin
                  adv_q <= fin_rdata;
                  state <= sup_gig ? S_RD_GIG : (sup_mg ? S_RD_MG : S_CHK);
               end
               S_RD_GIG: if (fin) begin
                  gig_q <= fin_rdata;
                  state <= sup_mg ? S_RD_MG : S_CHK;
               end
               S_RD_MG: if (fin) begin
                  mg_q  <= fin_rdata;
                  state <= S_CHK;
               end
               S_CHK: begin
                  if (mode_bad) begin
                     err_cfg <= 1'b1;
                     state   <= S_FINISH;
                  end else begin
                     adv_q <= adv_new;
                     gig_q <= gig_new;
                     mg_q  <= mg_new;
                     state <= S_WR_ADV;
                  end
               end
               S_WR_ADV: if (fin)
                  state <= sup_gig ? S_WR_GIG : (sup_mg ? S_WR_MG : S_RD_CTL);
               S_WR_GIG: if (fin)
                  state <= sup_mg ? S_WR_MG : S_RD_CTL;
               S_WR_MG: if (fin) state <= S_RD_CTL;
               S_RD_CTL: if (fin) begin
                  ctl_q <= fin_rdata;
                  state <= S_WR_CTL;
               end
               S_WR_CTL: if (fin) state <= wait_q ? S_POLL_A : S_FINISH;
               S_POLL_A: if (fin) state <= S_POLL_B;
               S_POLL_B: if (fin) begin
                  if (fin_rdata[STAT_AN_OK]) begin
                     an_complete <= 1'b1;
                     state       <= S_FINISH;
                  end else if (last_att) begin
                     state <= S_FINISH;
                  end else begin
                     state <= S_DELAY;
                  end
               end
               S_DELAY: if (dly_done) state <= S_POLL_A;
               S_FINISH: state <= S_IDLE;
               default: state <= S_IDLE;
            endcase
         end
      end
   end

   assign busy    = (state != S_IDLE);
   assign done    = (state == S_FINISH);
   assign recheck = (state == S_FINISH) && !err_cfg && !err_bus;

   // R4: half-duplex gigabit never advertised
   p_gig_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req && phy_we && phy_addr == A_GIG |-> !phy_wdata[GIG_HD]);
   // R5: transmit-only mode advertises asymmetric direction without pause
   p_pause_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req && phy_we && phy_addr == A_ADV && mode_q == FC_TX
      |-> phy_wdata[ADV_ASM] && !phy_wdata[ADV_PAUSE]);
   // R5: mode none advertises neither pause bit
   p_pause_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req && phy_we && phy_addr == A_ADV && mode_q == FC_NONE
      |-> !phy_wdata[ADV_ASM] && !phy_wdata[ADV_PAUSE]);
   // R6: no access while a configuration error stands
   p_cfg_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_cfg |-> !phy_req);
   // R7: control write carries enable and restart
   p_restart_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req && phy_we && phy_addr == A_CTL
      |-> phy_wdata[CTL_AN_EN] && phy_wdata[CTL_RESTART]);
   // R11: end-of-run pulse lasts one cycle
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10: after a bus error the port goes quiet
   p_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_bus |-> !phy_req);

endmodule

// File: tb/test_an_adv_seq.sv
`timescale 1ns/1ps
module test_an_adv_seq;

   localparam int AW = 21;
   localparam int DW = 16;
   localparam int PL = 4;
   localparam int DC = 10;
   localparam logic [AW-1:0] A_MG = AW'((7 << 16) | 32);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic start = 1'b0;
   logic [7:0] cap_req = '0, cap_support = '0;
   logic [2:0] fc_mode = '0;
   logic wait_done_en = 1'b0;
   logic busy, done, recheck, an_complete, err_cfg, err_bus;
   logic phy_req, phy_we, phy_ack, phy_err;
   logic [AW-1:0] phy_addr;
   logic [DW-1:0] phy_wdata, phy_rdata;

   an_adv_seq #(.ADDR_W(AW), .DATA_W(DW), .POLL_LIMIT(PL), .DELAY_CYC(DC)) i_an_adv_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cap_req(cap_req),
      .cap_support(cap_support), .fc_mode(fc_mode), .wait_done_en(wait_done_en),
      .busy(busy), .done(done), .recheck(recheck), .an_complete(an_complete),
      .err_cfg(err_cfg), .err_bus(err_bus), .phy_req(phy_req), .phy_we(phy_we),
      .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_ack(phy_ack),
      .phy_rdata(phy_rdata), .phy_err(phy_err)
   );

   // PHY register model
   logic ld = 1'b0;
   logic [15:0] ld_ctl = '0, ld_adv = '0, ld_gig = '0, ld_mg = '0;
   int ld_comp = 0, ld_err_at = 0;
   logic [15:0] m_ctl, m_adv, m_gig, m_mg;
   int comp_after, err_at, acc_cnt, wr_cnt, gig_cnt, stat_cnt, viol, cyc, last_stat, gap3;
   int n_done, n_rck;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (done) n_done <= n_done + 1;
      if (recheck) n_rck <= n_rck + 1;
      if (phy_ack && !phy_req) viol <= viol + 1;
      if (!rst_n) begin
         phy_ack <= 1'b0; phy_err <= 1'b0; phy_rdata <= '0;
         cyc <= 0; n_done <= 0; n_rck <= 0; viol <= 0;
      end else if (ld) begin
         m_ctl <= ld_ctl; m_adv <= ld_adv; m_gig <= ld_gig; m_mg <= ld_mg;
         comp_after <= ld_comp; err_at <= ld_err_at;
         acc_cnt <= 0; wr_cnt <= 0; gig_cnt <= 0; stat_cnt <= 0; gap3 <= 0;
         phy_ack <= 1'b0;
      end else begin
         phy_ack <= 1'b0;
         phy_err <= 1'b0;
         if (phy_req && !phy_ack) begin
            phy_ack <= 1'b1;
            acc_cnt <= acc_cnt + 1;
            if (phy_addr == AW'(9)) gig_cnt <= gig_cnt + 1;
            if (acc_cnt + 1 == err_at) begin
               phy_err <= 1'b1;
            end else if (phy_we) begin
               wr_cnt <= wr_cnt + 1;
               case (phy_addr)
                  AW'(0): m_ctl <= phy_wdata;
                  AW'(4): m_adv <= phy_wdata;
                  AW'(9): m_gig <= phy_wdata;
                  A_MG:   m_mg  <= phy_wdata;
                  default: ;
               endcase
            end else begin
               case (phy_addr)
                  AW'(0): phy_rdata <= m_ctl;
                  AW'(1): begin
                     phy_rdata <= (comp_after != 0 && stat_cnt + 1 >= comp_after) ? 16'h0020 : 16'h0000;
                     stat_cnt  <= stat_cnt + 1;
                     if (stat_cnt == 2) gap3 <= cyc - last_stat;
                     last_stat <= cyc;
                  end
                  AW'(4): phy_rdata <= m_adv;
                  AW'(9): phy_rdata <= m_gig;
                  A_MG:   phy_rdata <= m_mg;
                  default: phy_rdata <= '0;
               endcase
            end
         end
      end
   end

   int n_chk = 0, n_fail = 0;
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(logic [7:0] c, logic [7:0] s, logic [2:0] m, logic w,
                      logic [15:0] a0, logic [15:0] g0, logic [15:0] mg0,
                      int comp, int eat);
      int d0;
      @(negedge clk);
      ld = 1'b1; ld_ctl = 16'h0041; ld_adv = a0; ld_gig = g0; ld_mg = mg0;
      ld_comp = comp; ld_err_at = eat;
      @(negedge clk);
      ld = 1'b0;
      cap_req = c; cap_support = s; fc_mode = m; wait_done_en = w;
      d0 = n_done;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (n_done == d0) @(negedge clk);
      @(negedge clk);
   endtask

   typedef struct packed {
      logic [7:0]  cap;
      logic [7:0]  sup;
      logic [2:0]  mode;
      logic [15:0] a0, g0, m0, ea, eg, em;
      logic        cerr;
   } vec_t;

   localparam vec_t VT[6] = '{
      '{8'hFF, 8'hFF, 3'd3, 16'h0000, 16'h0000, 16'h0000, 16'h0DE0, 16'h0200, 16'h0080, 1'b0},
      '{8'h05, 8'hAF, 3'd0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hF2BF, 16'hFCFF, 16'hFF7F, 1'b0},
      '{8'h00, 8'h0F, 3'd2, 16'h0001, 16'h1234, 16'h5555, 16'h09E1, 16'h1234, 16'h5555, 1'b0},
      '{8'h50, 8'hFF, 3'd1, 16'h0000, 16'h0300, 16'h0080, 16'h0C00, 16'h0000, 16'h0000, 1'b0},
      '{8'hFF, 8'hFF, 3'd5, 16'h1111, 16'h2222, 16'h3333, 16'h1111, 16'h2222, 16'h3333, 1'b1},
      '{8'h30, 8'h3F, 3'd3, 16'h01E0, 16'h0100, 16'h0080, 16'h0C00, 16'h0200, 16'h0080, 1'b0}
   };

   initial begin
      #(5.0 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int r0;
      repeat (4) @(negedge clk);
      // R13 reset state
      chk("R13 busy", busy, 0);
      chk("R13 phy_req", phy_req, 0);
      chk("R13 errors", {err_cfg, err_bus, an_complete}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R1 R2 R3 R4 R5 R6 R7 R11
      for (int i = 0; i < 6; i++) begin
         r0 = n_rck;
         run(VT[i].cap, VT[i].sup, VT[i].mode, 1'b0, VT[i].a0, VT[i].g0, VT[i].m0, 0, 0);
         chk($sformatf("R3 R5 R1 adv v%0d", i), m_adv, VT[i].ea);
         chk($sformatf("R4 R2 gig v%0d", i), m_gig, VT[i].eg);
         chk($sformatf("R2 R4 mg v%0d", i), m_mg, VT[i].em);
         chk($sformatf("R6 err_cfg v%0d", i), err_cfg, VT[i].cerr);
         chk($sformatf("R7 ctl v%0d", i), m_ctl, VT[i].cerr ? 16'h0041 : 16'h1241);
         chk($sformatf("R11 recheck v%0d", i), n_rck - r0, VT[i].cerr ? 0 : 1);
         if (VT[i].cerr) chk("R6 no writes", wr_cnt, 0);
         if (i == 2) chk("R2 gig skipped", gig_cnt, 0);
         chk("R13 idle after run", busy, 0);
      end

      // R8: completion seen on third status read -> two attempts, four reads
      run(8'h0F, 8'hFF, 3'd3, 1'b1, 16'h0, 16'h0, 16'h0, 3, 0);
      chk("R8 status reads early", stat_cnt, 4);
      chk("R8 an_complete", an_complete, 1);
      chk("R9 attempt gap min", gap3 > DC, 1);
      chk("R9 attempt gap max", gap3 < DC + 10, 1);

      // R8: never completes -> exhaust, no error, recheck still pulses
      r0 = n_rck;
      run(8'h0F, 8'hFF, 3'd3, 1'b1, 16'h0, 16'h0, 16'h0, 0, 0);
      chk("R8 status reads exhaust", stat_cnt, 2 * PL);
      chk("R8 no complete", an_complete, 0);
      chk("R8 no bus error", err_bus, 0);
      chk("R11 recheck after exhaust", n_rck - r0, 1);

      // R10: error response on second access aborts the run
      r0 = n_rck;
      run(8'hFF, 8'hFF, 3'd3, 1'b0, 16'h1111, 16'h2222, 16'h3333, 0, 2);
      chk("R10 err_bus", err_bus, 1);
      chk("R10 access count", acc_cnt, 2);
      chk("R10 adv untouched", m_adv, 16'h1111);
      chk("R11 no recheck on error", n_rck - r0, 0);

      // R12 handshake held until acknowledge
      chk("R12 handshake violations", viol, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule